// File: doc/BRIEF.md
# ATA PIO Cycle Sequencer

This block runs one parallel-ATA programmed-I/O register access per host request. The host presents a register address, a direction bit and write data; the block then walks the bus through a fixed series of phases: a lead-in gap, address and chip-select setup, the read or write strobe, an address and data hold, and a release gap. It returns the captured read word with a one-cycle completion pulse.

Every phase length is a count of clock cycles taken from a bank of three 32-bit timing words that software loads. Fields are bytes, so any phase can run from 1 to 255 cycles. A zero field is stretched to one cycle, because software rounds every nanosecond figure up to at least one period. The drive's IORDY line passes through a two-flop synchroniser. When enabled, it can stretch the strobe at a programmed sample point.

The tri-state data pads are modelled as separate input, output and output-enable signals.

Top module: `pio_cycle_seq`

## Requirements
- R1: Timing fields are bytes. tmg_word0 holds, from bits 7:0 upward: release gap, lead-in gap, setup, write strobe width. tmg_word1 holds, from bits 7:0 upward: read strobe width, IORDY sample point, read capture delay, write data hold. tmg_word2 bits 7:0 hold the address hold; its bits 31:8 are ignored.
- R2: A field value of 0 behaves exactly as a value of 1.
- R3: A request (req_valid high while busy is low) is accepted at that clock edge. busy is high from the next cycle until the release gap ends. req_valid while busy is ignored, and the running access keeps its own address, direction and data.
- R4: After acceptance, all chip selects stay high for the lead-in count. Address and chip select are then valid for the setup count before the strobe falls. req_addr[3]=0 drives bus_cs_n[0] low and req_addr[3]=1 drives bus_cs_n[1] low; bus_addr carries req_addr[2:0]. At most one chip select is low at any time.
- R5: A write lowers only bus_wr_n, for the write strobe count; a read lowers only bus_rd_n, for the read strobe count.
- R6: On a write, bus_d_oe is high with bus_d_out equal to the request data from the first setup cycle until the write data hold count has elapsed after the strobe rises. On a read, bus_d_oe stays low.
- R7: Address and chip select stay valid for exactly the address hold count after the strobe rises.
- R8: On a read, bus_d_in is latched at the end of the cycle that lies (capture delay − 1) cycles after the strobe rises. rd_data holds that value from the done pulse until the next read capture.
- R9: The hold phase lasts the larger of the address hold and, for writes, the data hold or, for reads, the capture delay. It is followed by the release gap with all bus lines idle. done is a one-cycle pulse in the first cycle busy is low.
- R10: With iordy_en high, if the synchronised IORDY is low once the strobe has been low for the sample-point count, the strobe holds until IORDY is seen high. The rest of the strobe count then completes. A sample point at or beyond the strobe width causes no wait.
- R11: With iordy_en low, bus_iordy has no effect on any phase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_addr | input | 4 | Bit 3 selects the chip select, bits 2:0 the register |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last captured read word |
| tmg_word0 | input | 32 | Timing word 0 (release, lead-in, setup, write strobe) |
| tmg_word1 | input | 32 | Timing word 1 (read strobe, IORDY point, capture, data hold) |
| tmg_word2 | input | 32 | Timing word 2 (address hold in bits 7:0) |
| iordy_en | input | 1 | IORDY enable, bit 0 of the control word |
| bus_cs_n | output | 2 | Active-low chip selects |
| bus_addr | output | 3 | Register address lines |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_wr_n | output | 1 | Active-low write strobe |
| bus_d_out | output | 16 | Data driven to the bus |
| bus_d_oe | output | 1 | Data output enable |
| bus_d_in | input | 16 | Data read from the bus |
| bus_iordy | input | 1 | Asynchronous ready from the drive |

## Verification
Bus outputs decode the registered phase, so each one changes in the first cycle after the edge that enters a phase. The bench samples every output on the falling edge and counts, per access, the cycles of lead-in, setup, strobe, data hold and address hold. It compares each count with the clamped field values worked out from R1 and R2. The read word is due at the done pulse, which falls in the first cycle after the last release cycle; the bench records the bus value it drove in the capture cycle and compares it there. For the IORDY stall, IORDY is raised on a falling edge. Two synchroniser edges later the strobe counter resumes, so the bench expects one extra stalled cycle plus the remaining strobe count after the raise.

// File: rtl/pio_seq_pkg.sv
// Shared types for the PIO cycle sequencer.
// Assumes byte-wide timing fields packed into 32-bit words.
package pio_seq_pkg;

    localparam int FIELD_W = 8;
    localparam int WORD_W  = 32;

    // Bus phases of one access, in the order they are visited.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LEAD,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_RELEASE
    } pio_phase_e;

    // Clamped cycle counts, one per timing field.
    typedef struct packed {
        logic [FIELD_W-1:0] t_release;
        logic [FIELD_W-1:0] t_lead;
        logic [FIELD_W-1:0] t_setup;
        logic [FIELD_W-1:0] t_wr_pulse;
        logic [FIELD_W-1:0] t_rd_pulse;
        logic [FIELD_W-1:0] t_rdy_point;
        logic [FIELD_W-1:0] t_capture;
        logic [FIELD_W-1:0] t_data_hold;
        logic [FIELD_W-1:0] t_addr_hold;
    } pio_tmg_t;

    // A zero count still occupies one cycle.
    function automatic logic [FIELD_W-1:0] at_least_one(input logic [FIELD_W-1:0] v);
        return (v == '0) ? FIELD_W'(1) : v;
    endfunction

    function automatic logic [FIELD_W-1:0] max_cnt(input logic [FIELD_W-1:0] a,
                                                   input logic [FIELD_W-1:0] b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pio_iordy_sync.sv
// Multi-flop synchroniser for the asynchronous IORDY line.
// Assumes STAGES >= 2; resets to "ready" so no stall follows reset.
module pio_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], async_in};
    end

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/pio_tmg_unpack.sv
// Splits the three timing words into byte fields and clamps zero to one.
// Assumes the words are static for the duration of an access.
module pio_tmg_unpack
    import pio_seq_pkg::*;
(
    input  logic [WORD_W-1:0] word0,
    input  logic [WORD_W-1:0] word1,
    input  logic [WORD_W-1:0] word2,
    output pio_tmg_t          tmg
);
    logic [FIELD_W-1:0] raw [9];
    logic [FIELD_W-1:0] clamped [9];
    logic               unused_w2_hi;

    assign raw[0] = word0[7:0];
    assign raw[1] = word0[15:8];
    assign raw[2] = word0[23:16];
    assign raw[3] = word0[31:24];
    assign raw[4] = word1[7:0];
    assign raw[5] = word1[15:8];
    assign raw[6] = word1[23:16];
    assign raw[7] = word1[31:24];
    assign raw[8] = word2[7:0];
    assign unused_w2_hi = ^word2[WORD_W-1:FIELD_W];

    for (genvar i = 0; i < 9; i++) begin : g_clamp
        assign clamped[i] = at_least_one(raw[i]);
    end

    assign tmg.t_release   = clamped[0];
    assign tmg.t_lead      = clamped[1];
    assign tmg.t_setup     = clamped[2];
    assign tmg.t_wr_pulse  = clamped[3];
    assign tmg.t_rd_pulse  = clamped[4];
    assign tmg.t_rdy_point = clamped[5];
    assign tmg.t_capture   = clamped[6];
    assign tmg.t_data_hold = clamped[7];
    assign tmg.t_addr_hold = clamped[8];
endmodule

// File: rtl/pio_phase_ctrl.sv
// Phase sequencer: steps lead-in, setup, strobe, hold and release,
// each for its programmed count, with an IORDY stall inside the strobe.
// Assumes start is only raised while the phase is idle.
module pio_phase_ctrl
    import pio_seq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               is_write,
    input  pio_tmg_t           tmg,
    input  logic               iordy_en,
    input  logic               iordy_ok,
    output pio_phase_e         phase,
    output logic [FIELD_W-1:0] cnt,
    output logic               capture,
    output logic               done
);
    logic [FIELD_W-1:0] len;
    logic [FIELD_W-1:0] hold_len;
    logic               stall;
    logic               last;
    pio_phase_e         nxt_phase;

    // Hold covers the address hold and the direction's own trailing need.
    always_comb begin
        hold_len = max_cnt(tmg.t_addr_hold, is_write ? tmg.t_data_hold : tmg.t_capture);
    end

    // Length of the current phase and the phase that follows it.
    always_comb begin
        len       = FIELD_W'(1);
        nxt_phase = PH_IDLE;
        case (phase)
            PH_LEAD:    begin len = tmg.t_lead;    nxt_phase = PH_SETUP;   end
            PH_SETUP:   begin len = tmg.t_setup;   nxt_phase = PH_STROBE;  end
            PH_STROBE:  begin
                len       = is_write ? tmg.t_wr_pulse : tmg.t_rd_pulse;
                nxt_phase = PH_HOLD;
            end
            PH_HOLD:    begin len = hold_len;      nxt_phase = PH_RELEASE; end
            PH_RELEASE: begin len = tmg.t_release; nxt_phase = PH_IDLE;    end
            default:    begin len = FIELD_W'(1);   nxt_phase = PH_IDLE;    end
        endcase
    end

    // Freeze the strobe at the sample point while the drive is not ready.
    assign stall   = (phase == PH_STROBE) && iordy_en && !iordy_ok && (cnt == tmg.t_rdy_point);
    assign last    = (cnt == len - FIELD_W'(1));
    assign capture = (phase == PH_HOLD) && !is_write && (cnt == tmg.t_capture - FIELD_W'(1));

    // Advance the phase counter and step phases; pulse done on the way to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (phase == PH_IDLE) begin
                cnt <= '0;
                if (start) phase <= PH_LEAD;
            end else if (!stall) begin
                if (last) begin
                    phase <= nxt_phase;
                    cnt   <= '0;
                    done  <= (phase == PH_RELEASE);
                end else begin
                    cnt <= cnt + FIELD_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/pio_cycle_seq.sv
// Top of the PIO cycle sequencer: takes a request, latches it, runs the
// phase sequencer and decodes bus lines from the registered phase.
// Assumes CS_W chip selects addressed by the top request address bits.
module pio_cycle_seq
    import pio_seq_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 3,
    parameter int CS_W        = 2,
    parameter int SYNC_STAGES = 2,
    localparam int SEL_W      = (CS_W > 1) ? $clog2(CS_W) : 1,
    localparam int REQ_AW     = ADDR_W + SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [REQ_AW-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    input  logic [31:0]       tmg_word0,
    input  logic [31:0]       tmg_word1,
    input  logic [31:0]       tmg_word2,
    input  logic              iordy_en,
    output logic [CS_W-1:0]   bus_cs_n,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic [DATA_W-1:0] bus_d_out,
    output logic              bus_d_oe,
    input  logic [DATA_W-1:0] bus_d_in,
    input  logic              bus_iordy
);
    pio_tmg_t           tmg;
    pio_phase_e         phase;
    logic [FIELD_W-1:0] cnt;
    logic               capture;
    logic               iordy_ok;
    logic               start;
    logic               wr_q;
    logic [SEL_W-1:0]   sel_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  wdata_q;
    logic               addr_valid;
    logic               strobe_on;

    pio_tmg_unpack u_unpack (
        .word0 (tmg_word0),
        .word1 (tmg_word1),
        .word2 (tmg_word2),
        .tmg   (tmg)
    );

    pio_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_iordy),
        .sync_out (iordy_ok)
    );

    pio_phase_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .is_write (wr_q),
        .tmg      (tmg),
        .iordy_en (iordy_en),
        .iordy_ok (iordy_ok),
        .phase    (phase),
        .cnt      (cnt),
        .capture  (capture),
        .done     (done)
    );

    assign busy  = (phase != PH_IDLE);
    assign start = req_valid && !busy;

    // Hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            sel_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (start) begin
            wr_q    <= req_write;
            sel_q   <= req_addr[REQ_AW-1:ADDR_W];
            addr_q  <= req_addr[ADDR_W-1:0];
            wdata_q <= req_wdata;
        end
    end

    // Latch the bus word at the programmed capture cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data <= '0;
        else if (capture) rd_data <= bus_d_in;
    end

    // Address window spans setup, strobe and the address-hold part of hold.
    always_comb begin
        addr_valid = (phase == PH_SETUP) || (phase == PH_STROBE) ||
                     ((phase == PH_HOLD) && (cnt < tmg.t_addr_hold));
        strobe_on  = (phase == PH_STROBE);
        bus_d_oe   = wr_q && ((phase == PH_SETUP) || (phase == PH_STROBE) ||
                              ((phase == PH_HOLD) && (cnt < tmg.t_data_hold)));
    end

    for (genvar i = 0; i < CS_W; i++) begin : g_cs
        assign bus_cs_n[i] = !(addr_valid && (sel_q == SEL_W'(i)));
    end

    assign bus_addr  = addr_valid ? addr_q : '0;
    assign bus_rd_n  = !(strobe_on && !wr_q);
    assign bus_wr_n  = !(strobe_on && wr_q);
    assign bus_d_out = bus_d_oe ? wdata_q : '0;
endmodule

// File: rtl/pio_cycle_seq_checker.sv
// Protocol checker for the PIO cycle sequencer, bound to every instance.
// Assumes only the top module's ports; relates them over time.
module pio_cycle_seq_checker #(
    parameter int CS_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            busy,
    input logic            done,
    input logic [CS_W-1:0] bus_cs_n,
    input logic            bus_rd_n,
    input logic            bus_wr_n,
    input logic            bus_d_oe
);
    assert_single_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!bus_rd_n && !bus_wr_n));

    assert_cs_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~bus_cs_n));

    assert_strobe_in_cs_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_wr_n) |-> ($countones(~bus_cs_n) == 1));

    assert_read_no_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_d_oe);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    assert_busy_from_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (&bus_cs_n && bus_rd_n && bus_wr_n && !bus_d_oe));
endmodule

bind pio_cycle_seq pio_cycle_seq_checker #(.CS_W(CS_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .bus_cs_n  (bus_cs_n),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n),
    .bus_d_oe  (bus_d_oe)
);

// File: tb/pio_cycle_seq_test.sv
// Bench for the PIO cycle sequencer: directed corners plus seeded random
// accesses, every phase length counted on falling edges.
module pio_cycle_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        busy, done;
    logic [15:0] rd_data;
    logic [31:0] tmg_word0 = '0, tmg_word1 = '0, tmg_word2 = '0;
    logic        iordy_en = 1'b0;
    logic [1:0]  bus_cs_n;
    logic [2:0]  bus_addr;
    logic        bus_rd_n, bus_wr_n, bus_d_oe;
    logic [15:0] bus_d_out;
    logic [15:0] bus_d_in = '0;
    logic        bus_iordy = 1'b1;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pio_cycle_seq uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .done(done),
        .rd_data(rd_data), .tmg_word0(tmg_word0), .tmg_word1(tmg_word1),
        .tmg_word2(tmg_word2), .iordy_en(iordy_en), .bus_cs_n(bus_cs_n),
        .bus_addr(bus_addr), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n),
        .bus_d_out(bus_d_out), .bus_d_oe(bus_d_oe), .bus_d_in(bus_d_in),
        .bus_iordy(bus_iordy)
    );

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    // Byte field idx (0..3) of a word, zero counted as one (R1, R2).
    function automatic int fld(input logic [31:0] w, input int idx);
        int v;
        v = int'(w[idx*8 +: 8]);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [31:0] pack4(input int b0, input int b1, input int b2, input int b3);
        return {8'(b3), 8'(b2), 8'(b1), 8'(b0)};
    endfunction

    // One access; counts every phase at falling edges and compares.
    task automatic run_txn(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2,
                           input bit wr, input logic [3:0] ad, input logic [15:0] wd,
                           input bit en, input bit ready_low, input bit poke);
        int n_rel, n_lead, n_set, n_t2, n_ta, n_cap, n_dh, n_ah, n_hold, exp_strb;
        int n_pre, n_setup, n_strb, n_csa, n_oea, n_busy, h, bad_addr, bad_data, bad_strobe, guard;
        bit seen;
        logic [1:0]  exp_cs;
        logic [15:0] exp_rd;
        n_rel  = fld(w0, 0); n_lead = fld(w0, 1); n_set = fld(w0, 2);
        n_t2   = wr ? fld(w0, 3) : fld(w1, 0);
        n_ta   = fld(w1, 1); n_cap = fld(w1, 2); n_dh = fld(w1, 3); n_ah = fld(w2, 0);
        n_hold = imax(n_ah, wr ? n_dh : n_cap);
        exp_strb = (en && ready_low && n_ta < n_t2) ? n_t2 + 6 : n_t2;
        exp_cs = ad[3] ? 2'b01 : 2'b10;
        n_pre = 0; n_setup = 0; n_strb = 0; n_csa = 0; n_oea = 0; n_busy = 0; h = 0;
        bad_addr = 0; bad_data = 0; bad_strobe = 0; guard = 0; seen = 1'b0; exp_rd = '0;

        @(negedge clk);
        tmg_word0 = w0; tmg_word1 = w1; tmg_word2 = w2; iordy_en = en;
        bus_iordy = !ready_low;
        req_write = wr; req_addr = ad; req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (busy && guard < 3000) begin
            bit sl, csv;
            guard++;
            bus_d_in = 16'($urandom);
            n_busy++;
            sl  = wr ? !bus_wr_n : !bus_rd_n;
            csv = (bus_cs_n == exp_cs) && (bus_addr == ad[2:0]);
            if (wr ? !bus_rd_n : !bus_wr_n) bad_strobe++;
            if (sl) begin
                n_strb++;
                seen = 1'b1;
                if (!csv) bad_addr++;
                if (wr && (!bus_d_oe || bus_d_out != wd)) bad_data++;
                if (ready_low && en && n_strb == n_ta + 5) bus_iordy = 1'b1;
            end else if (!seen) begin
                if (&bus_cs_n) n_pre++;
                else begin
                    n_setup++;
                    if (!csv) bad_addr++;
                    if (bus_d_oe != wr) bad_data++;
                    if (wr && bus_d_out != wd) bad_data++;
                end
            end else begin
                if (csv) n_csa++;
                if (bus_d_oe) begin
                    n_oea++;
                    if (bus_d_out != wd) bad_data++;
                end
                if (!wr && h == n_cap - 1) exp_rd = bus_d_in;
                h++;
            end
            if (poke && n_busy == 2) begin
                req_valid = 1'b1; req_addr = ~ad; req_write = ~wr; req_wdata = ~wd;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(n_pre == n_lead, "R4 R1 R2 lead-in cycles", n_pre, n_lead);
        check(n_setup == n_set, "R4 setup cycles", n_setup, n_set);
        check(n_strb == exp_strb, "R5 R10 R11 strobe cycles", n_strb, exp_strb);
        check(bad_strobe == 0, "R5 wrong strobe cycles", bad_strobe, 0);
        check(bad_addr == 0, "R4 R3 address/cs mismatches", bad_addr, 0);
        check(n_csa == n_ah, "R7 address hold cycles", n_csa, n_ah);
        check(n_oea == (wr ? n_dh : 0), "R6 data hold cycles", n_oea, wr ? n_dh : 0);
        check(bad_data == 0, "R6 R3 data drive mismatches", bad_data, 0);
        check(n_busy == n_lead + n_set + exp_strb + n_hold + n_rel, "R9 R3 busy cycles",
              n_busy, n_lead + n_set + exp_strb + n_hold + n_rel);
        check(done === 1'b1 && busy === 1'b0, "R9 done with busy low", int'(done), 1);
        if (!wr) check(rd_data == exp_rd, "R8 read capture", int'(rd_data), int'(exp_rd));
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, "R9 R3 done pulse single, no extra access",
              int'({done, busy}), 0);
        bus_iordy = 1'b1;
    endtask

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1357);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && rd_data == 16'h0, "R3 reset idle", int'(busy), 0);
        check(bus_cs_n == 2'b11 && bus_rd_n && bus_wr_n && !bus_d_oe, "R9 reset bus idle",
              int'(bus_cs_n), 3);

        // R2: all-zero bank behaves as all ones.
        run_txn('0, '0, '0, 1'b1, 4'h5, 16'hA5A5, 1'b0, 1'b0, 1'b0);
        run_txn('0, '0, '0, 1'b0, 4'hB, 16'h0000, 1'b0, 1'b0, 1'b0);
        // R10: stall at sample point 3 inside an 8-cycle read strobe.
        run_txn(pack4(2, 3, 2, 4), pack4(8, 3, 1, 2), 32'hFFFF_FF02, 1'b0, 4'h2, 16'h0, 1'b1, 1'b1, 1'b0);
        // R11: IORDY low but disabled.
        run_txn(pack4(2, 3, 2, 4), pack4(8, 3, 1, 2), 32'h0000_0002, 1'b0, 4'h2, 16'h0, 1'b0, 1'b1, 1'b0);
        // R10: sample point beyond the write strobe, no wait.
        run_txn(pack4(1, 1, 1, 8), pack4(3, 9, 1, 2), 32'h0000_0003, 1'b1, 4'hC, 16'h1234, 1'b1, 1'b1, 1'b0);
        // R3: request while busy is ignored.
        run_txn(pack4(2, 2, 2, 3), pack4(3, 3, 1, 2), 32'h0000_0002, 1'b1, 4'h9, 16'hBEEF, 1'b0, 1'b0, 1'b1);
        // R6/R8/R9: data hold and capture longer than the address hold.
        run_txn(pack4(1, 1, 1, 2), pack4(2, 3, 1, 6), 32'h0000_0001, 1'b1, 4'h1, 16'h7E81, 1'b0, 1'b0, 1'b0);
        run_txn(pack4(3, 1, 1, 2), pack4(2, 3, 5, 1), 32'h0000_0002, 1'b0, 4'hF, 16'h0, 1'b0, 1'b0, 1'b0);

        // R1: random banks with small fields and noise in word2's upper bits.
        for (int i = 0; i < 40; i++) begin
            logic [31:0] w0, w1, w2;
            w0 = pack4($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6));
            w1 = pack4($urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6), $urandom_range(0, 6));
            w2 = {24'($urandom), 8'($urandom_range(0, 6))};
            run_txn(w0, w1, w2, 1'($urandom), 4'($urandom), 16'($urandom), 1'($urandom), 1'b0, (i % 7) == 3);
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R9 actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule